// File: doc/BRIEF.md
# LCD Dot-Clock Timing Generator

This block produces the sync and data-enable waveforms for a parallel RGB panel. It advances by one pixel on every dot-clock tick. All geometry is taken from configuration inputs that software keeps static while the block is idle:

- the line period and the frame length;
- the widths of the sync pulses;
- the cumulative wait counts, each of which already includes its sync width;
- the number of valid pixels per line and the number of active lines.

A pixel request strobe leads data-enable by one clock, so a fetch unit has one cycle to present the pixel. A start-of-frame pulse marks the first clock of every frame.

A next-frame base address may be written at any time. It is copied into the current-address output only on the first clock of a frame, so a pan never takes effect partway through a picture. The sync outputs have their own enable, separate from run. When run is cleared, the frame in progress completes before the block goes idle. All three panel outputs have a polarity input.

Top module: `lcd_timing_gen`

## Requirements
- R1: While reset is held, busy_o, sof_o and pix_req_o are 0, cur_addr_o is 0, and hs_o, vs_o and de_o sit at their inactive levels.
- R2: While running, consecutive start-of-frame pulses are exactly line_period × frame_lines clocks apart.
- R3: The horizontal sync output is asserted for the first hs_width clocks of every line and is deasserted for the rest of the line.
- R4: With vs_in_lines=1, the vertical sync output is asserted for the first vs_width whole lines of each frame.
- R5: With vs_in_lines=0, the vertical sync output is asserted for the first vs_width clocks of each frame, counted across line boundaries.
- R6: Data-enable is asserted on line clocks h_wait to h_wait+h_valid-1, and only in lines v_wait to v_wait+v_valid-1 of the frame.
- R7: pix_req_o is active high and is asserted exactly one clock before each clock on which data-enable is asserted.
- R8: A polarity input of 1 makes its output active high; a polarity input of 0 makes it active low. The inactive level is the inverse of the polarity input, including while idle.
- R9: While sync_on is 0, hs_o and vs_o stay at their inactive levels. Data-enable and pix_req_o are unaffected by sync_on.
- R10: cur_addr_o takes the value of next_addr on the start-of-frame clock and holds its value on every other clock.
- R11: After run is cleared, the current frame runs to its last clock. On the clock after that last clock busy_o is 0. From then on no start-of-frame pulse occurs and all panel outputs stay at their inactive levels until run is set again.
- R12: sof_o is a one-clock pulse, coincident with the first clock of line 0 of each frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Start frames; when cleared, stop at the end of the current frame |
| sync_on | input | 1 | Enable for the horizontal and vertical sync outputs |
| vs_in_lines | input | 1 | 1: vsync width is counted in lines; 0: vsync width is counted in clocks |
| pol_hs | input | 1 | Horizontal sync polarity (1 = active high) |
| pol_vs | input | 1 | Vertical sync polarity (1 = active high) |
| pol_de | input | 1 | Data-enable polarity (1 = active high) |
| line_period | input | CW | Clocks per line, including all margins and the sync pulse |
| hs_width | input | CW | Horizontal sync width in clocks |
| h_wait | input | CW | Clocks from line start to the first valid pixel (sync width plus left margin) |
| h_valid | input | CW | Valid pixels per line |
| frame_lines | input | CW | Lines per frame, including all margins and the sync pulse |
| vs_width | input | CW | Vertical sync width, in lines or clocks |
| v_wait | input | CW | Lines from frame start to the first active line (sync width plus upper margin) |
| v_valid | input | CW | Active lines per frame |
| next_addr | input | AW | Base address for the next frame |
| hs_o | output | 1 | Horizontal sync to the panel |
| vs_o | output | 1 | Vertical sync to the panel |
| de_o | output | 1 | Data-enable to the panel |
| pix_req_o | output | 1 | Pixel request, one clock ahead of data-enable |
| sof_o | output | 1 | Start-of-frame pulse |
| busy_o | output | 1 | Frame counters are running |
| cur_addr_o | output | AW | Base address of the frame being shown |

## Verification
The assertions rely on a few assumptions about the inputs:

- each frame is longer than one clock;
- the polarity inputs do not change in the clock between a pixel request and the data-enable it predicts;
- the geometry inputs change only while busy_o is low.

The bench respects these assumptions. It changes geometry only after it has seen busy_o fall, and it draws random margins, widths and active sizes from small ranges that keep every wait count at least as large as its sync width. Directed frames add the corners: zero left and upper margins, a zero right margin so that data-enable reaches the last clock of the line, a clock-counted vertical sync spanning several lines, and a stop request issued mid-frame.

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen #(
  parameter int CW = 12,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          sync_on,
  input  logic          vs_in_lines,
  input  logic          pol_hs,
  input  logic          pol_vs,
  input  logic          pol_de,
  input  logic [CW-1:0] line_period,
  input  logic [CW-1:0] hs_width,
  input  logic [CW-1:0] h_wait,
  input  logic [CW-1:0] h_valid,
  input  logic [CW-1:0] frame_lines,
  input  logic [CW-1:0] vs_width,
  input  logic [CW-1:0] v_wait,
  input  logic [CW-1:0] v_valid,
  input  logic [AW-1:0] next_addr,
  output logic          hs_o,
  output logic          vs_o,
  output logic          de_o,
  output logic          pix_req_o,
  output logic          sof_o,
  output logic          busy_o,
  output logic [AW-1:0] cur_addr_o
);

  localparam int EW = CW + 1;

  logic          act;
  logic [CW-1:0] hc, vc, fc;
  logic          hs_a, vs_a, de_a, sof_q;
  logic [AW-1:0] cur_q;

  logic line_end, frame_end, frame_start;
  logic h_sync, v_sync, h_in, v_in;
  logic [EW-1:0] h_stop, v_stop;

  assign line_end    = hc == line_period - 1'b1;
  assign frame_end   = line_end && (vc == frame_lines - 1'b1);
  assign frame_start = act && hc == '0 && vc == '0;

  assign h_stop = {1'b0, h_wait} + {1'b0, h_valid};
  assign v_stop = {1'b0, v_wait} + {1'b0, v_valid};

  assign h_sync = hc < hs_width;
  assign v_sync = vs_in_lines ? (vc < vs_width) : (fc < vs_width);
  assign h_in   = (hc >= h_wait) && ({1'b0, hc} < h_stop);
  assign v_in   = (vc >= v_wait) && ({1'b0, vc} < v_stop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= 1'b0;
      hc  <= '0;
      vc  <= '0;
      fc  <= '0;
    end else if (!act) begin
      act <= run;
      hc  <= '0;
      vc  <= '0;
      fc  <= '0;
    end else begin
      hc <= line_end ? '0 : hc + 1'b1;
      if (line_end)
        vc <= frame_end ? '0 : vc + 1'b1;
      if (frame_end)
        fc <= '0;
      else if (fc != '1)
        fc <= fc + 1'b1;
      if (frame_end && !run)
        act <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_a  <= 1'b0;
      vs_a  <= 1'b0;
      de_a  <= 1'b0;
      sof_q <= 1'b0;
      cur_q <= '0;
    end else begin
      hs_a  <= act && sync_on && h_sync;
      vs_a  <= act && sync_on && v_sync;
      de_a  <= pix_req_o;
      sof_q <= frame_start;
      if (frame_start)
        cur_q <= next_addr;
    end
  end

  assign pix_req_o  = act && h_in && v_in;
  assign hs_o       = ~(hs_a ^ pol_hs);
  assign vs_o       = ~(vs_a ^ pol_vs);
  assign de_o       = ~(de_a ^ pol_de);
  assign sof_o      = sof_q;
  assign busy_o     = act;
  assign cur_addr_o = cur_q;

endmodule

// File: rtl/lcd_timing_gen_chk.sv
module lcd_timing_gen_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sync_on,
  input logic          pol_hs,
  input logic          pol_vs,
  input logic          pol_de,
  input logic [AW-1:0] next_addr,
  input logic          hs_o,
  input logic          vs_o,
  input logic          de_o,
  input logic          pix_req_o,
  input logic          sof_o,
  input logic          busy_o,
  input logic [AW-1:0] cur_addr_o
);

  p_sof_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    sof_o |=> !sof_o);

  p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !sof_o |-> $stable(cur_addr_o));

  p_addr_copy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sof_o |-> cur_addr_o == $past(next_addr));

  p_req_lead_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pix_req_o |=> de_o == pol_de);

  p_sync_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sync_on) |-> (hs_o != pol_hs) && (vs_o != pol_vs));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !$past(busy_o)) |-> (hs_o != pol_hs) && (vs_o != pol_vs) && (de_o != pol_de) && !pix_req_o);

  p_idle_no_sof_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |=> !sof_o);

endmodule

bind lcd_timing_gen lcd_timing_gen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_on(sync_on),
  .pol_hs(pol_hs), .pol_vs(pol_vs), .pol_de(pol_de),
  .next_addr(next_addr), .hs_o(hs_o), .vs_o(vs_o), .de_o(de_o),
  .pix_req_o(pix_req_o), .sof_o(sof_o), .busy_o(busy_o), .cur_addr_o(cur_addr_o)
);

// File: tb/test_lcd_timing_gen.sv
`timescale 1ns/1ps
module test_lcd_timing_gen;
  localparam int CW = 12;
  localparam int AW = 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, run, sync_on, vs_in_lines, pol_hs, pol_vs, pol_de;
  logic [CW-1:0] line_period, hs_width, h_wait, h_valid, frame_lines, vs_width, v_wait, v_valid;
  logic [AW-1:0] next_addr;
  logic hs_o, vs_o, de_o, pix_req_o, sof_o, busy_o;
  logic [AW-1:0] cur_addr_o;

  lcd_timing_gen #(.CW(CW), .AW(AW)) i_lcd_timing_gen (.*);

  int n_chk = 0, n_fail = 0;
  int hsw, hl, hv, hr, vsw, vu, vv, vl, P, L, N;
  bit vlines, ssync;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit lvl(input bit asrt, input bit pol);
    return asrt ? pol : !pol;
  endfunction

  function automatic bit e_hs(input int i);
    return ssync && ((i % P) < hsw);
  endfunction

  function automatic bit e_vs(input int i);
    return ssync && (vlines ? ((i / P) < vsw) : (i < vsw));
  endfunction

  function automatic bit e_de(input int i);
    int h = i % P;
    int l = i / P;
    return (h >= hsw + hl) && (h < hsw + hl + hv) && (l >= vsw + vu) && (l < vsw + vu + vv);
  endfunction

  task automatic apply();
    P = hsw + hl + hv + hr;
    L = vu + vv + vl + (vlines ? vsw : 1);
    if (L < 2) L = 2;
    N = P * L;
    line_period = CW'(P);
    hs_width    = CW'(hsw);
    h_wait      = CW'(hsw + hl);
    h_valid     = CW'(hv);
    frame_lines = CW'(L);
    vs_width    = CW'(vsw);
    v_wait      = CW'(vsw + vu);
    v_valid     = CW'(vv);
    vs_in_lines = vlines;
    sync_on     = ssync;
    pol_hs      = 1'($urandom_range(1, 0));
    pol_vs      = 1'($urandom_range(1, 0));
    pol_de      = 1'($urandom_range(1, 0));
  endtask

  task automatic frame(input bit stop);
    int t = 0;
    logic [AW-1:0] old_a, new_a;
    string vtag;
    vtag = !ssync ? "R9 vsync gated" : (vlines ? "R4 vsync lines" : "R5 vsync clocks");
    @(negedge clk);
    apply();
    run = 1'b1;
    while (!sof_o && t < 4000) begin @(negedge clk); t++; end
    chk(sof_o, "R12 sof after start", sof_o, 1);
    old_a = cur_addr_o;
    new_a = $urandom;
    for (int i = 0; i <= N; i++) begin
      if (i < N) begin
        chk(hs_o == lvl(e_hs(i), pol_hs), ssync ? "R3/R8 hsync" : "R9 hsync gated", hs_o, lvl(e_hs(i), pol_hs));
        chk(vs_o == lvl(e_vs(i), pol_vs), vtag, vs_o, lvl(e_vs(i), pol_vs));
        chk(de_o == lvl(e_de(i), pol_de), "R6/R8 data enable", de_o, lvl(e_de(i), pol_de));
        if (stop && i == N - 1)
          chk(pix_req_o == 1'b0, "R11 no request after stop", pix_req_o, 0);
        else
          chk(pix_req_o == e_de((i + 1) % N), "R7 pixel request", pix_req_o, e_de((i + 1) % N));
        chk(sof_o == (i == 0), "R12 sof single pulse", sof_o, i == 0);
      end
      if (i > 3 && i < N) chk(cur_addr_o == old_a, "R10 address held", cur_addr_o, old_a);
      if (stop) begin
        if (i <= N - 2) chk(busy_o == 1'b1, "R11 frame completes", busy_o, 1);
        if (i == N - 1) chk(busy_o == 1'b0, "R11 idle after frame", busy_o, 0);
      end
      if (i == N) begin
        if (stop) begin
          chk(sof_o == 1'b0, "R11 no new frame", sof_o, 0);
        end else begin
          chk(sof_o == 1'b1, "R2 frame length", sof_o, 1);
          chk(cur_addr_o == new_a, "R10 address copied", cur_addr_o, new_a);
        end
      end
      if (i == 3) next_addr = new_a;
      if (stop && i == 5) run = 1'b0;
      if (i < N) @(negedge clk);
    end
    if (stop) begin
      for (int k = 0; k < 2 * N; k++) begin
        @(negedge clk);
        chk(!sof_o && !busy_o && hs_o != pol_hs && vs_o != pol_vs && de_o != pol_de,
            "R11 stays idle", {sof_o, busy_o}, 0);
      end
    end else begin
      run = 1'b0;
      t = 0;
      while (busy_o && t < 2 * N + 8) begin @(negedge clk); t++; end
      chk(!busy_o, "R11 stops", busy_o, 0);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; run = 1'b0; sync_on = 1'b0; vs_in_lines = 1'b1;
    pol_hs = 1'b0; pol_vs = 1'b1; pol_de = 1'b0;
    line_period = '0; hs_width = '0; h_wait = '0; h_valid = '0;
    frame_lines = '0; vs_width = '0; v_wait = '0; v_valid = '0;
    next_addr = 32'h1000;
    repeat (3) @(negedge clk);
    chk(hs_o == 1'b1, "R1 reset hsync inactive", hs_o, 1);
    chk(vs_o == 1'b0, "R1 reset vsync inactive", vs_o, 0);
    chk(de_o == 1'b1, "R1 reset de inactive", de_o, 1);
    chk(!busy_o && !sof_o && !pix_req_o, "R1 reset strobes", {busy_o, sof_o, pix_req_o}, 0);
    chk(cur_addr_o == '0, "R1 reset address", cur_addr_o, 0);
    rst_n = 1'b1;

    // directed: no left or upper margin, data-enable reaching line end
    hsw = 2; hl = 0; hv = 5; hr = 0; vsw = 1; vu = 0; vv = 3; vl = 1; vlines = 1; ssync = 1;
    frame(1'b0);
    // directed: clock-counted vsync spanning several lines
    hsw = 1; hl = 1; hv = 3; hr = 2; vsw = 17; vu = 1; vv = 2; vl = 1; vlines = 0; ssync = 1;
    frame(1'b0);
    // directed: sync outputs disabled
    hsw = 3; hl = 2; hv = 4; hr = 1; vsw = 2; vu = 1; vv = 3; vl = 1; vlines = 1; ssync = 0;
    frame(1'b0);
    // directed: stop request mid-frame
    hsw = 2; hl = 1; hv = 4; hr = 2; vsw = 2; vu = 1; vv = 2; vl = 1; vlines = 1; ssync = 1;
    frame(1'b1);

    for (int r = 0; r < 8; r++) begin
      hsw = $urandom_range(4, 1); hl = $urandom_range(3, 0);
      hv  = $urandom_range(6, 1); hr = $urandom_range(3, 1);
      vlines = 1'($urandom_range(1, 0));
      vsw = vlines ? $urandom_range(3, 1) : $urandom_range(30, 1);
      vu  = $urandom_range(2, 0); vv = $urandom_range(4, 1); vl = $urandom_range(2, 0);
      ssync = 1'($urandom_range(3, 0) != 0);
      frame(r == 5);
    end

    @(negedge clk);
    pol_hs = 1'b1; pol_vs = 1'b0; pol_de = 1'b1;
    #1;
    chk(hs_o == 1'b0, "R8 idle hsync active-high pol", hs_o, 0);
    chk(vs_o == 1'b1, "R8 idle vsync active-low pol", vs_o, 1);
    chk(de_o == 1'b0, "R8 idle de active-high pol", de_o, 0);
    pol_hs = 1'b0;
    #1;
    chk(hs_o == 1'b1, "R8 idle hsync active-low pol", hs_o, 1);
    finish_run();
  end
endmodule